// File: doc/BRIEF.md
# Power-Fail Supervisor and Write Lockout

This block watches the state of a main supply through three digitized level flags and turns them into three control outputs for a battery-backed memory subsystem. The flags say whether the supply is above the write-protect trip level, above the battery switchover level, and above the full-operation level. The outputs are a processor reset request, a write-lockout flag that tells the memory to ignore its inputs and float its data outputs, and a battery-select flag for the power switch.

While the supply is below the trip level, the block holds reset and lockout. When the supply comes back, two millisecond-tick timers start once the supply is above the full-operation level. Lockout ends after `WP_MS` ticks and reset ends after `RST_MS` ticks. The two limits are separate parameters, so tests can shorten them. If the supply drops under the trip level at any point, both timers go back to zero and both outputs assert again. Battery selection follows its own, lower threshold and does not depend on the timers. Every flag passes through a two-flop synchronizer before the block uses it.

Top module: `pfs_supervisor`

## Requirements
- R1: While `rst_n` is low, and after it rises with every supply flag still low, `por_req_n` is 0, `wr_lock` is 1 and `bat_sel` is 1.
- R2: A change on any supply flag reaches the outputs on the second rising clock edge after the new level is present, and not on the first.
- R3: When `vok_wp` goes low, `wr_lock` goes to 1 and `por_req_n` goes to 0 after the synchronizer latency, whatever the timers hold.
- R4: Once `vok_wp` and `vok_full` are both high, `wr_lock` stays 1 through `WP_MS-1` qualifying ticks and drops to 0 on the clock edge that samples the `WP_MS`-th tick.
- R5: Under the same conditions, `por_req_n` stays 0 through `RST_MS-1` qualifying ticks and rises to 1 on the clock edge that samples the `RST_MS`-th tick. After that it stays 1 for any number of further ticks.
- R6: The two release points are independent. With `WP_MS` < `RST_MS`, the bench sees lockout released while reset is still requested.
- R7: A tick sampled while `vok_full` is low does not advance either timer.
- R8: After release, if `vok_full` falls while `vok_wp` stays high, neither reset nor lockout asserts again.
- R9: `bat_sel` equals the inverse of `vok_sw` after the synchronizer latency (1 selects the battery), independent of the other flags and the timers.
- R10: If `vok_wp` falls while the timers are running, both timers restart from zero. A later power-up needs the full `WP_MS` and `RST_MS` tick counts again.
- R11: `por_req_n` is an open-drain-style request: 0 means pull the reset line low and 1 means release it to an external pull-up. The block never actively drives the line high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Supervisor clock |
| rst_n | input | 1 | Synchronous active-low register reset |
| ms_tick | input | 1 | One-cycle pulse every millisecond |
| vok_wp | input | 1 | Supply is above the write-protect trip level (asynchronous) |
| vok_sw | input | 1 | Supply is above the battery switchover level (asynchronous) |
| vok_full | input | 1 | Supply is above the full-operation level (asynchronous) |
| por_req_n | output | 1 | Reset request: 0 = pull low, 1 = released |
| wr_lock | output | 1 | 1 = block memory writes and float data outputs |
| bat_sel | output | 1 | 1 = run the memory from the battery |

## Verification
The bench counts ticks up to one short of each limit and then exactly to it. A design with an off-by-one count would release a tick early or a tick late. It drops the trip flag part way through a power-up and then requires the full tick count again; a design that only pauses its timers would release too soon. It also gives ticks while only the trip flag is high, and lets the supply sag between the trip and full-operation levels after release. These cases catch a timer that counts with no qualifying supply, and a supervisor with no hysteresis that re-locks on the sag. Finally, it samples one edge after a flag changes, where a design that skipped a synchronizer stage would already have moved its output.

// File: rtl/pfs_pkg.sv
// Package: shared types for the power-fail supervisor.
// Assumes the three supply flags are thresholds ordered switchover < trip < full.
package pfs_pkg;

    // Synchronized view of the supply comparator flags.
    typedef struct packed {
        logic full_ok;   // above full-operation level
        logic sw_ok;     // above battery switchover level
        logic wp_ok;     // above write-protect trip level
    } supply_flags_t;

    localparam int FLAG_W = $bits(supply_flags_t);

endpackage

// File: rtl/pfs_sync.sv
// Module: pfs_sync
// Two-flop synchronizer, one chain per bit. Resets every stage to 0, which
// means "supply absent".
// Assumes each input bit is a level that is asynchronous to clk.
module pfs_sync #(
    parameter int WIDTH = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    genvar gi;
    generate
        for (gi = 0; gi < WIDTH; gi++) begin : g_bit
            logic stage1;
            logic stage2;

            // Two-stage capture of one asynchronous flag.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    stage1 <= 1'b0;
                    stage2 <= 1'b0;
                end else begin
                    stage1 <= async_in[gi];
                    stage2 <= stage1;
                end
            end

            assign sync_out[gi] = stage2;
        end
    endgenerate

endmodule

// File: rtl/pfs_delay.sv
// Module: pfs_delay
// Post-power-up delay. Counts sampled ticks while enable is high and raises
// done on the edge that samples the LEN-th tick. Clear has priority and
// restarts the count from zero.
// Assumes LEN >= 1 and that tick lasts one clock cycle.
module pfs_delay #(
    parameter int LEN = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic enable,
    input  logic tick,
    output logic done
);

    localparam int CW = $clog2(LEN + 1);
    localparam logic [CW-1:0] LAST = CW'(LEN - 1);

    logic [CW-1:0] count;

    // Tick counter that saturates by stopping once done is set.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            count <= '0;
            done  <= 1'b0;
        end else if (enable && tick && !done) begin
            count <= count + 1'b1;
            done  <= (count == LAST);
        end
    end

endmodule

// File: rtl/pfs_supervisor.sv
// Module: pfs_supervisor (top)
// Power-fail supervisor. It synchronizes the supply flags, holds reset and
// write lockout while the supply is below the trip level, and releases each
// output after its own tick count. Battery selection follows the
// switchover flag on its own.
// Assumes ms_tick is a one-cycle pulse. por_req_n is meant to drive an
// open-drain pad: 0 pulls the line low and 1 releases it.
module pfs_supervisor #(
    parameter int RST_MS = 200,
    parameter int WP_MS  = 125
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ms_tick,
    input  logic vok_wp,
    input  logic vok_sw,
    input  logic vok_full,
    output logic por_req_n,
    output logic wr_lock,
    output logic bat_sel
);

    import pfs_pkg::*;

    supply_flags_t raw_flags;
    supply_flags_t flags;
    logic          fault;
    logic          rst_done;
    logic          wp_done;

    assign raw_flags = '{full_ok: vok_full, sw_ok: vok_sw, wp_ok: vok_wp};

    pfs_sync #(.WIDTH(FLAG_W)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (raw_flags),
        .sync_out (flags)
    );

    // Out-of-tolerance supply: below the write-protect trip level.
    assign fault = !flags.wp_ok;

    pfs_delay #(.LEN(RST_MS)) u_rst_delay (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (fault),
        .enable (flags.full_ok),
        .tick   (ms_tick),
        .done   (rst_done)
    );

    pfs_delay #(.LEN(WP_MS)) u_wp_delay (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (fault),
        .enable (flags.full_ok),
        .tick   (ms_tick),
        .done   (wp_done)
    );

    // Output decode. Every term is a register, so the outputs do not glitch.
    always_comb begin
        por_req_n = !fault && rst_done;
        wr_lock   = fault || !wp_done;
        bat_sel   = !flags.sw_ok;
    end

endmodule

// File: rtl/pfs_supervisor_chk.sv
// Module: pfs_supervisor_chk
// Property checker, bound to pfs_supervisor. It watches only the ports.
// Assumes the synchronizer latency is two clock edges.
module pfs_supervisor_chk #(
    parameter int RST_MS = 200,
    parameter int WP_MS  = 125
) (
    input logic clk,
    input logic rst_n,
    input logic ms_tick,
    input logic vok_wp,
    input logic vok_sw,
    input logic por_req_n,
    input logic wr_lock,
    input logic bat_sel
);

    // A supply below the trip level forces reset and lockout.
    p_fault_locks_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(vok_wp, 2) |-> (wr_lock && !por_req_n));

    // Battery select tracks the switchover flag.
    p_bat_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bat_sel == !$past(vok_sw, 2));

    // Lockout only releases on a sampled tick.
    p_lock_release_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wr_lock) |-> $past(ms_tick));

    // Reset only releases on a sampled tick.
    p_rst_release_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(por_req_n) |-> $past(ms_tick));

    // With the shorter lockout delay, a released reset means released lockout.
    p_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (por_req_n && (WP_MS <= RST_MS)) |-> !wr_lock);

endmodule

bind pfs_supervisor pfs_supervisor_chk #(.RST_MS(RST_MS), .WP_MS(WP_MS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ms_tick   (ms_tick),
    .vok_wp    (vok_wp),
    .vok_sw    (vok_sw),
    .por_req_n (por_req_n),
    .wr_lock   (wr_lock),
    .bat_sel   (bat_sel)
);

// File: tb/pfs_supervisor_bench.sv
// Scoreboard bench for pfs_supervisor. Driver tasks push expected output
// triples into a queue, and a monitor pops and compares them.
module pfs_supervisor_bench;

    localparam int RST_T = 8;
    localparam int WP_T  = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ms_tick = 1'b0;
    logic vok_wp = 1'b0;
    logic vok_sw = 1'b0;
    logic vok_full = 1'b0;
    logic por_req_n;
    logic wr_lock;
    logic bat_sel;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    typedef struct {
        logic  por;
        logic  lock;
        logic  bat;
        string tag;
    } exp_t;

    exp_t exp_q[$];

    always #4 clk = ~clk;

    pfs_supervisor #(.RST_MS(RST_T), .WP_MS(WP_T)) u_pfs_supervisor (
        .clk       (clk),
        .rst_n     (rst_n),
        .ms_tick   (ms_tick),
        .vok_wp    (vok_wp),
        .vok_sw    (vok_sw),
        .vok_full  (vok_full),
        .por_req_n (por_req_n),
        .wr_lock   (wr_lock),
        .bat_sel   (bat_sel)
    );

    // Driver: queue one expected output triple for the current sample point.
    task automatic expect_out(input logic por, input logic lock, input logic bat,
                              input string tag);
        exp_t e;
        e.por = por; e.lock = lock; e.bat = bat; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            ms_tick = 1'b1;
            @(negedge clk);
            ms_tick = 1'b0;
            @(negedge clk);
        end
    endtask

    // Monitor: just after each falling edge, compare the queued expectations.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                checks++;
                if (por_req_n !== e.por || wr_lock !== e.lock || bat_sel !== e.bat) begin
                    errors++;
                    $display("FAIL %s: actual por=%b lock=%b bat=%b expected por=%b lock=%b bat=%b",
                             e.tag, por_req_n, wr_lock, bat_sel, e.por, e.lock, e.bat);
                end
            end
        end
    end

    // Stimulus.
    initial begin
        cyc(3);
        expect_out(0, 1, 1, "R1 during reset");
        rst_n = 1'b1;
        cyc(3);
        expect_out(0, 1, 1, "R1 after reset, no supply");

        // Switchover flag: one edge is not enough, two edges are.
        vok_sw = 1'b1;
        cyc(1);
        expect_out(0, 1, 1, "R2 one edge after sw flag");
        cyc(1);
        expect_out(0, 1, 0, "R9 external supply selected");

        // Above trip but not full: ticks must not count.
        vok_wp = 1'b1;
        cyc(3);
        tick(WP_T + 1);
        expect_out(0, 1, 0, "R7 ticks below full level ignored");

        // Full power-up sequence.
        vok_full = 1'b1;
        cyc(3);
        tick(WP_T - 1);
        expect_out(0, 1, 0, "R4 lock held one tick short");
        tick(1);
        expect_out(0, 0, 0, "R4 R6 lock released, reset still held");
        tick(RST_T - WP_T - 1);
        expect_out(0, 0, 0, "R5 reset held one tick short");
        tick(1);
        expect_out(1, 0, 0, "R5 R11 reset released");
        tick(3);
        expect_out(1, 0, 0, "R5 stays released");

        // Sag between trip and full levels: no re-lock.
        vok_full = 1'b0;
        cyc(3);
        expect_out(1, 0, 0, "R8 sag above trip ignored");

        // Drop below trip.
        vok_wp = 1'b0;
        cyc(1);
        expect_out(1, 0, 0, "R2 one edge after trip flag");
        cyc(1);
        expect_out(0, 1, 0, "R3 trip locks and resets");

        // Battery switchover, independent of the other outputs.
        vok_sw = 1'b0;
        cyc(2);
        expect_out(0, 1, 1, "R9 battery selected");
        vok_sw = 1'b1;
        cyc(2);
        expect_out(0, 1, 0, "R9 external reselected");

        // Interrupted power-up restarts both timers.
        vok_wp = 1'b1;
        vok_full = 1'b1;
        cyc(3);
        tick(3);
        vok_wp = 1'b0;
        cyc(2);
        expect_out(0, 1, 0, "R10 drop during delay relocks");
        vok_wp = 1'b1;
        cyc(3);
        tick(WP_T - 1);
        expect_out(0, 1, 0, "R10 lock count restarted from zero");
        tick(1);
        expect_out(0, 0, 0, "R10 lock released after full count");
        tick(RST_T - WP_T - 1);
        expect_out(0, 0, 0, "R10 reset count restarted from zero");
        tick(1);
        expect_out(1, 0, 0, "R10 reset released after full count");

        cyc(3);
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog.
    initial begin
        #(8 * 200000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule